// File: doc/BRIEF.md
# Accumulator Processor Core

A small processor built around one 32-bit accumulator. It fetches 20-bit instruction words from an external instruction memory, addressed by its program counter, and runs them one at a time through a fixed multicycle sequence. Both memories are external and synchronous: read data appears one clock after the address. The data memory is 32 bits wide and word addressed, with 16 address bits.

Each instruction carries a 4-bit opcode and a 16-bit operand. For load, store, add and subtract the operand is a data memory address. For the immediate load it is a constant. For the jumps it is a target address. Add and subtract never wrap. If the result does not fit in 32 unsigned bits, the core raises `halt` and freezes in place until it is reset.

Top module: `acc_core`

## Requirements
- R1: An instruction word is 20 bits: opcode in bits [19:16], operand in bits [15:0]. Opcode values are: load 1, store 2, add 3, subtract 4, jump 5, jump-if-zero 6, jump-if-nonzero 7, immediate 8.
- R2: While `rst` is high at a rising edge, the core clears the program counter, accumulator, zero flag and halt. After reset, `instrAddr` is 0, `halt` is 0 and `dataWrEn` is 0.
- R3: Load (1) copies the data word at address operand into the accumulator.
- R4: Store (2) drives `dataAddr` = operand and `dataWrData` = accumulator, with `dataWrEn` high for exactly one cycle. Writes happen only for this opcode.
- R5: Add (3) sets the accumulator to accumulator + mem[operand] when the unsigned sum is below 2^32. Otherwise it asserts `halt`, leaves the accumulator unchanged, and does not advance the program counter.
- R6: Subtract (4) sets the accumulator to accumulator − mem[operand] when mem[operand] ≤ accumulator. Otherwise it halts, with the same frozen state as R5.
- R7: Immediate (8) loads the operand into the accumulator, zero-extended to 32 bits.
- R8: Jump (5) loads the operand into the program counter. Jump-if-zero (6) does so only when the zero flag is 1. Jump-if-nonzero (7) does so only when the zero flag is 0. In every other case the program counter advances by one.
- R9: The zero flag is set to (new accumulator == 0) by load, add, subtract and immediate. It is left unchanged by store and by all jumps.
- R10: Opcode 0 and opcodes 9 through 15 change nothing except advancing the program counter by one. They never write data memory.
- R11: Once `halt` is 1, it stays 1 until reset. `instrAddr` holds its value and `dataWrEn` stays 0.
- R12: From the cycle an instruction's address appears on `instrAddr`, the program counter changes after 4 rising edges for load, add and subtract, and after 3 rising edges for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instrAddr | output | 16 | Instruction memory address (the program counter) |
| instrData | input | 20 | Instruction word, valid one cycle after its address |
| dataAddr | output | 16 | Data memory address (the current operand) |
| dataWrEn | output | 1 | Data memory write strobe |
| dataWrData | output | 32 | Data memory write value (the accumulator) |
| dataRdData | input | 32 | Data memory read value, valid one cycle after its address |
| halt | output | 1 | Arithmetic fault: the core has stopped |

## Verification
The cycle-level assertions cover four properties. The accumulator is never written with an overflowing sum or a negative difference. The program counter only holds, steps by one, or takes the operand. The zero flag always agrees with the accumulator after an update. A halted core issues no strobes and never clears `halt` without reset. Whether the arithmetic, the immediate zero extension and the jump conditions give the right values can only be shown by the bench's directed programs. The same applies to no-operation opcodes leaving memory alone and to the cycle count per instruction. The bench checks these through the data memory contents and the program counter's path.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_SUB   = 4'd4;
  localparam logic [OPC_W-1:0] OP_JUMP  = 4'd5;
  localparam logic [OPC_W-1:0] OP_JZ    = 4'd6;
  localparam logic [OPC_W-1:0] OP_JNZ   = 4'd7;
  localparam logic [OPC_W-1:0] OP_IMM   = 4'd8;

  typedef enum logic [1:0] {SEL_MEM, SEL_SUM, SEL_DIFF, SEL_IMM} acc_sel_e;

  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_MEMRD, ST_EXEC, ST_STOP} phase_e;

  typedef struct packed {
    logic     irLoad;
    logic     pcInc;
    logic     pcLoad;
    logic     accLoad;
    acc_sel_e accSel;
    logic     zeroLoad;
    logic     memWrite;
    logic     haltSet;
  } strobe_t;
endpackage

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_core_pkg::*;
#(
  parameter int OPND_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  strobe_t                 st,
  input  logic [OPC_W+OPND_W-1:0] instrData,
  input  logic [DATA_W-1:0]       memRd,
  output logic [OPC_W-1:0]        opcode,
  output logic [OPND_W-1:0]       operand,
  output logic [OPND_W-1:0]       pc,
  output logic [DATA_W-1:0]       acc,
  output logic                    zeroFlag,
  output logic                    sumOvf,
  output logic                    diffNeg,
  output logic                    halt
);
  localparam int INSTR_W = OPC_W + OPND_W;
  localparam int PAD_W   = DATA_W - OPND_W;

  logic [INSTR_W-1:0] ir;
  logic [DATA_W:0]    sumWide;
  logic [DATA_W-1:0]  accNext;

  assign opcode  = ir[INSTR_W-1 -: OPC_W];
  assign operand = ir[OPND_W-1:0];
  assign sumWide = {1'b0, acc} + {1'b0, memRd};
  assign sumOvf  = sumWide[DATA_W];
  assign diffNeg = memRd > acc;

  always_comb begin
    unique case (st.accSel)
      SEL_MEM:  accNext = memRd;
      SEL_SUM:  accNext = sumWide[DATA_W-1:0];
      SEL_DIFF: accNext = acc - memRd;
      default:  accNext = {{PAD_W{1'b0}}, operand};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir       <= '0;
      pc       <= '0;
      acc      <= '0;
      zeroFlag <= 1'b0;
      halt     <= 1'b0;
    end else begin
      if (st.irLoad)   ir       <= instrData;
      if (st.pcLoad)   pc       <= operand;
      else if (st.pcInc) pc     <= pc + 1'b1;
      if (st.accLoad)  acc      <= accNext;
      if (st.zeroLoad) zeroFlag <= (accNext == '0);
      if (st.haltSet)  halt     <= 1'b1;
    end
  end

  // R2: reset clears the architectural state
  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && !zeroFlag && !halt));
  // R5: an overflowing sum is never committed
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (st.accLoad && st.accSel == SEL_SUM) |-> !sumOvf);
  // R6: a negative difference is never committed
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (st.accLoad && st.accSel == SEL_DIFF) |-> !diffNeg);
  // R8: the program counter holds, steps or takes the operand
  a_r8_pc_moves: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc == $past(pc) || pc == $past(pc) + 1'b1 || pc == $past(operand)));
  // R9: the zero flag agrees with the accumulator after an update
  a_r9_zero_tracks: assert property (@(posedge clk) disable iff (rst)
    st.zeroLoad |=> (zeroFlag == (acc == '0)));
  // R11: halt is sticky
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);
endmodule

// File: rtl/acc_control.sv
module acc_control
  import acc_core_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] fetchOp,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zeroFlag,
  input  logic             sumOvf,
  input  logic             diffNeg,
  input  logic             halt,
  output strobe_t          st
);
  phase_e phase, phaseNext;
  logic   needsRead;

  assign needsRead = (fetchOp == OP_LOAD) || (fetchOp == OP_ADD) || (fetchOp == OP_SUB);

  always_comb begin
    st        = '0;
    phaseNext = phase;
    unique case (phase)
      ST_FETCH:  phaseNext = ST_DECODE;
      ST_DECODE: begin
        st.irLoad = 1'b1;
        phaseNext = needsRead ? ST_MEMRD : ST_EXEC;
      end
      ST_MEMRD:  phaseNext = ST_EXEC;
      ST_EXEC: begin
        st.pcInc = 1'b1;
        unique case (opcode)
          OP_LOAD: begin
            st.accLoad = 1'b1; st.accSel = SEL_MEM; st.zeroLoad = 1'b1;
          end
          OP_STORE: st.memWrite = 1'b1;
          OP_ADD: begin
            if (sumOvf) begin
              st.haltSet = 1'b1; st.pcInc = 1'b0;
            end else begin
              st.accLoad = 1'b1; st.accSel = SEL_SUM; st.zeroLoad = 1'b1;
            end
          end
          OP_SUB: begin
            if (diffNeg) begin
              st.haltSet = 1'b1; st.pcInc = 1'b0;
            end else begin
              st.accLoad = 1'b1; st.accSel = SEL_DIFF; st.zeroLoad = 1'b1;
            end
          end
          OP_JUMP: st.pcLoad = 1'b1;
          OP_JZ:   st.pcLoad = zeroFlag;
          OP_JNZ:  st.pcLoad = !zeroFlag;
          OP_IMM: begin
            st.accLoad = 1'b1; st.accSel = SEL_IMM; st.zeroLoad = 1'b1;
          end
          default: ;
        endcase
        phaseNext = st.haltSet ? ST_STOP : ST_FETCH;
      end
      default:   phaseNext = ST_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= ST_FETCH;
    else     phase <= phaseNext;
  end

  // R4: memory writes come only from an executing store
  a_r4_write_only_store: assert property (@(posedge clk) disable iff (rst)
    st.memWrite |-> (opcode == OP_STORE && phase == ST_EXEC));
  // R11: a halted core issues no strobes
  a_r11_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    halt |-> (st == '0 && phase == ST_STOP));
  // R12: the program counter moves only at the end of execution
  a_r12_pc_in_exec: assert property (@(posedge clk) disable iff (rst)
    (st.pcInc || st.pcLoad) |-> phase == ST_EXEC);
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int OPND_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [OPND_W-1:0]       instrAddr,
  input  logic [OPC_W+OPND_W-1:0] instrData,
  output logic [OPND_W-1:0]       dataAddr,
  output logic                    dataWrEn,
  output logic [DATA_W-1:0]       dataWrData,
  input  logic [DATA_W-1:0]       dataRdData,
  output logic                    halt
);
  localparam int INSTR_W = OPC_W + OPND_W;

  strobe_t           st;
  logic [OPC_W-1:0]  opcode;
  logic [OPND_W-1:0] operand;
  logic [OPND_W-1:0] pc;
  logic [DATA_W-1:0] acc;
  logic              zeroFlag, sumOvf, diffNeg;

  acc_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .fetchOp  (instrData[INSTR_W-1 -: OPC_W]),
    .opcode   (opcode),
    .zeroFlag (zeroFlag),
    .sumOvf   (sumOvf),
    .diffNeg  (diffNeg),
    .halt     (halt),
    .st       (st)
  );

  acc_datapath #(.OPND_W(OPND_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .instrData (instrData),
    .memRd     (dataRdData),
    .opcode    (opcode),
    .operand   (operand),
    .pc        (pc),
    .acc       (acc),
    .zeroFlag  (zeroFlag),
    .sumOvf    (sumOvf),
    .diffNeg   (diffNeg),
    .halt      (halt)
  );

  assign instrAddr  = pc;
  assign dataAddr   = operand;
  assign dataWrEn   = st.memWrite;
  assign dataWrData = acc;
endmodule

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instrAddr;
  logic [19:0] instrData;
  logic [15:0] dataAddr;
  logic        dataWrEn;
  logic [31:0] dataWrData;
  logic [31:0] dataRdData;
  logic        halt;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int haltWrites = 0;

  logic [19:0] imem [64];
  logic [31:0] dmem [256];

  always #2.5 clk = ~clk;

  acc_core dut_i (
    .clk(clk), .rst(rst), .instrAddr(instrAddr), .instrData(instrData),
    .dataAddr(dataAddr), .dataWrEn(dataWrEn), .dataWrData(dataWrData),
    .dataRdData(dataRdData), .halt(halt)
  );

  // synchronous memories, one cycle read latency
  always @(posedge clk) begin
    instrData  <= imem[instrAddr[5:0]];
    dataRdData <= dmem[dataAddr[7:0]];
    if (dataWrEn) dmem[dataAddr[7:0]] <= dataWrData;
    if (halt && dataWrEn) haltWrites <= haltWrites + 1;
    cycles <= cycles + 1;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [19:0] ins(input logic [3:0] op, input logic [15:0] arg);
    return {op, arg};
  endfunction

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic holdReset();
    rst = 1'b1;
    for (int i = 0; i < 64; i++) imem[i] = 20'h0;
    for (int i = 0; i < 256; i++) dmem[i] = 32'h0;
    haltWrites = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runTo(input string req, input int endAddr);
    bit hit = 0;
    rst = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (instrAddr == endAddr[15:0]) begin hit = 1; break; end
    end
    checkEq(req, {31'b0, hit}, 32'd1);
    repeat (4) @(negedge clk);
  endtask

  task automatic runToHalt(input string req);
    bit hit = 0;
    rst = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (halt) begin hit = 1; break; end
    end
    checkEq(req, {31'b0, hit}, 32'd1);
  endtask

  task automatic testReset();
    holdReset();
    checkEq("R2 instrAddr", {16'b0, instrAddr}, 32'd0);
    checkEq("R2 halt", {31'b0, halt}, 32'd0);
    checkEq("R2 dataWrEn", {31'b0, dataWrEn}, 32'd0);
  endtask

  task automatic testTiming();
    int n;
    holdReset();
    imem[0] = ins(4'd8, 16'd1);
    imem[1] = ins(4'd1, 16'd0);
    imem[2] = ins(4'd5, 16'd2);
    rst = 1'b0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); n++; @(negedge clk);
      if (instrAddr != 16'd0) break;
    end
    checkEq("R12 imm edges", n, 32'd3);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); n++; @(negedge clk);
      if (instrAddr != 16'd1) break;
    end
    checkEq("R12 load edges", n, 32'd4);
  endtask

  task automatic testImmStore();
    holdReset();
    imem[0] = ins(4'd8, 16'h1234);
    imem[1] = ins(4'd2, 16'd10);
    imem[2] = ins(4'd8, 16'hFFFF);
    imem[3] = ins(4'd2, 16'd11);
    imem[4] = ins(4'd5, 16'd4);
    runTo("R8 reach end", 4);
    checkEq("R7 R4 imm store", dmem[10], 32'h0000_1234);
    checkEq("R7 zero extend", dmem[11], 32'h0000_FFFF);
  endtask

  task automatic testLoadAdd();
    holdReset();
    dmem[20] = 32'd100;
    dmem[21] = 32'hFFFF_FF00;
    imem[0] = ins(4'd1, 16'd20);
    imem[1] = ins(4'd3, 16'd21);
    imem[2] = ins(4'd2, 16'd30);
    imem[3] = ins(4'd1, 16'd21);
    imem[4] = ins(4'd2, 16'd31);
    imem[5] = ins(4'd5, 16'd5);
    runTo("R3 reach end", 5);
    checkEq("R5 sum", dmem[30], 32'hFFFF_FF64);
    checkEq("R3 load", dmem[31], 32'hFFFF_FF00);
    checkEq("R5 no halt", {31'b0, halt}, 32'd0);
  endtask

  task automatic testSub();
    holdReset();
    dmem[1] = 32'd7;
    dmem[2] = 32'd3;
    imem[0] = ins(4'd8, 16'd10);
    imem[1] = ins(4'd4, 16'd2);
    imem[2] = ins(4'd2, 16'd4);
    imem[3] = ins(4'd8, 16'd7);
    imem[4] = ins(4'd4, 16'd1);
    imem[5] = ins(4'd2, 16'd5);
    imem[6] = ins(4'd6, 16'd8);
    imem[7] = ins(4'd5, 16'd7);
    imem[8] = ins(4'd5, 16'd8);
    runTo("R6 R9 zero result jumps", 8);
    checkEq("R6 difference", dmem[4], 32'd7);
    checkEq("R6 exact zero", dmem[5], 32'd0);
  endtask

  task automatic testJumps();
    holdReset();
    imem[0]  = ins(4'd8, 16'd0);
    imem[1]  = ins(4'd6, 16'd4);
    imem[2]  = ins(4'd8, 16'h11);
    imem[3]  = ins(4'd2, 16'd40);
    imem[4]  = ins(4'd8, 16'h22);
    imem[5]  = ins(4'd7, 16'd8);
    imem[6]  = ins(4'd8, 16'h33);
    imem[7]  = ins(4'd2, 16'd40);
    imem[8]  = ins(4'd2, 16'd41);
    imem[9]  = ins(4'd6, 16'd12);
    imem[10] = ins(4'd2, 16'd42);
    imem[11] = ins(4'd5, 16'd11);
    imem[12] = ins(4'd5, 16'd12);
    runTo("R8 jump path", 11);
    checkEq("R8 skipped stores", dmem[40], 32'd0);
    checkEq("R8 jnz taken", dmem[41], 32'h22);
    checkEq("R8 jz not taken", dmem[42], 32'h22);
  endtask

  task automatic testZeroKeep();
    holdReset();
    // store must not disturb a set zero flag; load of a zero word sets it
    dmem[60] = 32'd0;
    imem[0] = ins(4'd8, 16'd5);
    imem[1] = ins(4'd1, 16'd60);
    imem[2] = ins(4'd8, 16'd0);
    imem[3] = ins(4'd8, 16'd0);
    imem[4] = ins(4'd2, 16'd50);
    imem[5] = ins(4'd6, 16'd7);
    imem[6] = ins(4'd5, 16'd6);
    imem[7] = ins(4'd5, 16'd7);
    runTo("R9 store keeps zero", 7);
    holdReset();
    dmem[60] = 32'd0;
    imem[0] = ins(4'd8, 16'd5);
    imem[1] = ins(4'd1, 16'd60);
    imem[2] = ins(4'd6, 16'd4);
    imem[3] = ins(4'd5, 16'd3);
    imem[4] = ins(4'd5, 16'd4);
    runTo("R9 load sets zero", 4);
  endtask

  task automatic testNop();
    holdReset();
    dmem[50] = 32'hAAAA;
    dmem[51] = 32'hBBBB;
    imem[0] = ins(4'd8, 16'd9);
    imem[1] = ins(4'd0, 16'd50);
    imem[2] = ins(4'd9, 16'd50);
    imem[3] = ins(4'd15, 16'd51);
    imem[4] = ins(4'd2, 16'd52);
    imem[5] = ins(4'd5, 16'd5);
    runTo("R10 nop advance", 5);
    checkEq("R10 no write 50", dmem[50], 32'hAAAA);
    checkEq("R10 no write 51", dmem[51], 32'hBBBB);
    checkEq("R10 acc kept", dmem[52], 32'd9);
  endtask

  task automatic testOverflow();
    holdReset();
    dmem[1] = 32'hFFFF_FFFE;
    dmem[5] = 32'hFFFF_FFFF;
    imem[0] = ins(4'd8, 16'd1);
    imem[1] = ins(4'd3, 16'd1);
    imem[2] = ins(4'd2, 16'd4);
    imem[3] = ins(4'd3, 16'd5);
    imem[4] = ins(4'd2, 16'd6);
    imem[5] = ins(4'd5, 16'd5);
    runToHalt("R5 overflow halts");
    checkEq("R5 max sum", dmem[4], 32'hFFFF_FFFF);
    checkEq("R5 pc frozen", {16'b0, instrAddr}, 32'd3);
    repeat (30) @(negedge clk);
    checkEq("R11 halt held", {31'b0, halt}, 32'd1);
    checkEq("R11 pc held", {16'b0, instrAddr}, 32'd3);
    checkEq("R11 no store", dmem[6], 32'd0);
    checkEq("R11 no writes", haltWrites, 32'd0);
    rst = 1'b1;
    @(negedge clk);
    checkEq("R2 halt cleared", {31'b0, halt}, 32'd0);
    checkEq("R2 pc cleared", {16'b0, instrAddr}, 32'd0);
  endtask

  task automatic testUnderflow();
    holdReset();
    dmem[1] = 32'd8;
    imem[0] = ins(4'd8, 16'd7);
    imem[1] = ins(4'd4, 16'd1);
    imem[2] = ins(4'd2, 16'd3);
    imem[3] = ins(4'd5, 16'd3);
    runToHalt("R6 underflow halts");
    checkEq("R6 pc frozen", {16'b0, instrAddr}, 32'd1);
    checkEq("R6 no store", dmem[3], 32'd0);
  endtask

  initial begin
    testReset();
    testTiming();
    testImmStore();   // R1 field layout used by every program
    testLoadAdd();
    testSub();
    testJumps();
    testZeroKeep();
    testNop();
    testOverflow();
    testUnderflow();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule